// File: doc/BRIEF.md
# Multi-Cycle Single-Bus Accumulator Processor

This block is a small accumulator machine. Its registers (program counter, memory address register, memory data register, instruction register and accumulator) share one internal data bus. A step sequencer performs one register transfer per clock. Every instruction begins with the same three-cycle fetch. An execute phase follows, and its length depends on the opcode. The block drives a single-port memory with one address, separate read and write strobes, and separate data-in and data-out buses.

The instruction word is 16 bits wide. The upper nibble selects the operation and the lower twelve bits name a memory word. The operations are load, store, add, unconditional jump, branch-when-zero-flag-clear, load through a pointer, and load through a pointer that is first decremented and written back. A halt opcode stops sequencing. The current program counter, accumulator, zero flag and halt state are brought out so that the surrounding system can observe them.

Top module: `acc_cpu`

## Requirements
- R1: While rst_n is low, pc_out, acc_out and zero_out read 0 and halted is low. After release, the first fetch reads address 0 in the second cycle.
- R2: A fetch takes three cycles. The first cycle has no memory access. The second asserts mem_rd with mem_addr equal to the program counter, and at its end pc_out increments by one. The third cycle splits the word.
- R3: Bits 15:12 of an instruction are the opcode and bits 11:0 are the operand address x. The encodings are 0 load, 1 store, 2 add, 3 jump, 4 branch-if-Z-clear, 5 load-indirect, 6 load-indirect-with-pre-decrement and 15 halt.
- R4: Load (opcode 0) sets the accumulator to M[x] in 5 cycles and leaves the zero flag unchanged.
- R5: Store (opcode 1) writes the accumulator to M[x] in 5 cycles. mem_rd and mem_wr are never high in the same cycle.
- R6: Add (opcode 2) sets the accumulator to (AC + M[x]) mod 2^16 in 5 cycles. It sets zero_out exactly when that result is 0. No other instruction changes zero_out.
- R7: Jump (opcode 3) sets the program counter to x in 4 cycles.
- R8: Branch (opcode 4) takes 4 cycles. It sets the program counter to x when zero_out is 0. Otherwise execution continues at the next word.
- R9: Load-indirect (opcode 5) reads pointer P = M[x] and sets the accumulator to M[P[11:0]] in 7 cycles.
- R10: Pre-decrement load (opcode 6) reads P = M[x] and writes (P - 1) mod 2^16 back to x. It then sets the accumulator to M[(P-1)[11:0]]. It takes 9 cycles.
- R11: Halt (opcode 15) raises halted at the end of its single execute cycle. halted stays high until reset. While halted, there is no memory access and the program counter and accumulator hold.
- R12: Opcodes 7 to 14 use one execute cycle and change neither the accumulator nor the zero flag. Execution resumes at the next word.
- R13: Read data on mem_rdata is sampled at the end of the cycle that asserts mem_rd. A write commits at the end of the cycle that asserts mem_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the strobe cycle |
| halted | output | 1 | Halt state |
| pc_out | output | 12 | Program counter |
| acc_out | output | 16 | Accumulator |
| zero_out | output | 1 | Zero flag |

## Verification
The checker assumes that the memory answers within the strobe cycle, so that mem_rdata reflects mem_addr while mem_rd is high. It also assumes that rst_n changes only between edges. The bench model reads its array combinationally from the address and writes on the clock edge. All programs, pointers and operands stay inside its 256-word window, which includes the pointer that wraps from 0 down to the top of that window. Reset is driven and released on falling edges.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LDA = 4'h0,
    OP_STA = 4'h1,
    OP_ADD = 4'h2,
    OP_JMP = 4'h3,
    OP_BNZ = 4'h4,
    OP_LDI = 4'h5,
    OP_LDD = 4'h6,
    OP_HLT = 4'hF
  } opcode_e;

  typedef enum logic [1:0] {
    BUS_NONE = 2'd0,
    BUS_PC   = 2'd1,
    BUS_MDR  = 2'd2,
    BUS_AC   = 2'd3
  } bus_src_e;

  typedef struct packed {
    bus_src_e src;
    logic     ld_mar;
    logic     ld_ir;
    logic     ld_pc;
    logic     inc_pc;
    logic     mdr_from_bus;
    logic     mdr_from_mem;
    logic     dec_mdr;
    logic     ld_ac;
    logic     add_ac;
    logic     mem_rd;
    logic     mem_wr;
    logic     last;
    logic     halt;
  } ctrl_t;
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu #(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] sum,
  output logic              is_zero
);
  always_comb begin
    sum     = op_a + op_b;
    is_zero = (sum == '0);
  end
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OP_W-1:0]     ir_op,
  input  logic                zero_flag,
  output ctrl_t               cw,
  output logic                halted
);
  localparam int unsigned FETCH_N = 3;

  logic [STEP_W-1:0] step_q, step_d;
  logic              halt_q, halt_d;
  logic [STEP_W-1:0] ex;

  // control word for the current step
  always_comb begin
    cw = '0;
    ex = step_q - STEP_W'(FETCH_N);
    if (!halt_q) begin
      if (step_q == STEP_W'(0)) begin
        cw.src    = BUS_PC;
        cw.ld_mar = 1'b1;
      end else if (step_q == STEP_W'(1)) begin
        cw.mem_rd       = 1'b1;
        cw.mdr_from_mem = 1'b1;
        cw.inc_pc       = 1'b1;
      end else if (step_q == STEP_W'(2)) begin
        cw.src    = BUS_MDR;
        cw.ld_ir  = 1'b1;
        cw.ld_mar = 1'b1;
      end else begin
        case (ir_op)
          OP_LDA, OP_ADD: begin
            if (ex == STEP_W'(0)) begin
              cw.mem_rd       = 1'b1;
              cw.mdr_from_mem = 1'b1;
            end else begin
              cw.src    = BUS_MDR;
              cw.ld_ac  = (ir_op == OP_LDA);
              cw.add_ac = (ir_op == OP_ADD);
              cw.last   = 1'b1;
            end
          end
          OP_STA: begin
            if (ex == STEP_W'(0)) begin
              cw.src          = BUS_AC;
              cw.mdr_from_bus = 1'b1;
            end else begin
              cw.mem_wr = 1'b1;
              cw.last   = 1'b1;
            end
          end
          OP_JMP, OP_BNZ: begin
            cw.src   = BUS_MDR;
            cw.ld_pc = (ir_op == OP_JMP) || !zero_flag;
            cw.last  = 1'b1;
          end
          OP_LDI: begin
            case (ex)
              STEP_W'(0), STEP_W'(2): begin
                cw.mem_rd       = 1'b1;
                cw.mdr_from_mem = 1'b1;
              end
              STEP_W'(1): begin
                cw.src    = BUS_MDR;
                cw.ld_mar = 1'b1;
              end
              default: begin
                cw.src   = BUS_MDR;
                cw.ld_ac = 1'b1;
                cw.last  = 1'b1;
              end
            endcase
          end
          OP_LDD: begin
            case (ex)
              STEP_W'(0), STEP_W'(4): begin
                cw.mem_rd       = 1'b1;
                cw.mdr_from_mem = 1'b1;
              end
              STEP_W'(1): cw.dec_mdr = 1'b1;
              STEP_W'(2): cw.mem_wr  = 1'b1;
              STEP_W'(3): begin
                cw.src    = BUS_MDR;
                cw.ld_mar = 1'b1;
              end
              default: begin
                cw.src   = BUS_MDR;
                cw.ld_ac = 1'b1;
                cw.last  = 1'b1;
              end
            endcase
          end
          OP_HLT:  cw.halt = 1'b1;
          default: cw.last = 1'b1;
        endcase
      end
    end
  end

  // sequencer next state
  always_comb begin
    step_d = step_q;
    halt_d = halt_q;
    if (!halt_q) begin
      if (cw.halt)      halt_d = 1'b1;
      else if (cw.last) step_d = '0;
      else              step_d = step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      halt_q <= 1'b0;
    end else begin
      step_q <= step_d;
      halt_q <= halt_d;
    end
  end

  assign halted = halt_q;
endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = WORD_W - OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             cw,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [OP_W-1:0]   ir_op,
  output logic [ADDR_W-1:0] mar,
  output logic [WORD_W-1:0] mdr,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] acc,
  output logic              zero_flag
);
  logic [WORD_W-1:0] bus;
  logic [ADDR_W-1:0] pc_q, pc_d, mar_q;
  logic [WORD_W-1:0] mdr_q, mdr_d, acc_q, acc_d, alu_sum;
  logic [OP_W-1:0]   ir_q;
  logic              z_q, z_d, alu_zero;

  // single shared bus, one source per cycle
  always_comb begin
    case (cw.src)
      BUS_PC:  bus = {{(WORD_W-ADDR_W){1'b0}}, pc_q};
      BUS_MDR: bus = mdr_q;
      BUS_AC:  bus = acc_q;
      default: bus = '0;
    endcase
  end

  acc_cpu_alu #(.WORD_W(WORD_W)) u_alu (
    .op_a    (acc_q),
    .op_b    (bus),
    .sum     (alu_sum),
    .is_zero (alu_zero)
  );

  always_comb begin
    pc_d = pc_q;
    if (cw.ld_pc)       pc_d = bus[ADDR_W-1:0];
    else if (cw.inc_pc) pc_d = pc_q + ADDR_W'(1);

    mdr_d = mdr_q;
    if (cw.mdr_from_mem)      mdr_d = mem_rdata;
    else if (cw.mdr_from_bus) mdr_d = bus;
    else if (cw.dec_mdr)      mdr_d = mdr_q - WORD_W'(1);

    acc_d = acc_q;
    z_d   = z_q;
    if (cw.ld_ac) acc_d = bus;
    else if (cw.add_ac) begin
      acc_d = alu_sum;
      z_d   = alu_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      acc_q <= '0;
      z_q   <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      acc_q <= acc_d;
      z_q   <= z_d;
    end
  end

  // staging registers, no reset
  always_ff @(posedge clk) begin
    mdr_q <= mdr_d;
    if (cw.ld_mar) mar_q <= bus[ADDR_W-1:0];
    if (cw.ld_ir)  ir_q  <= bus[WORD_W-1:ADDR_W];
  end

  assign ir_op     = ir_q;
  assign mar       = mar_q;
  assign mdr       = mdr_q;
  assign pc        = pc_q;
  assign acc       = acc_q;
  assign zero_flag = z_q;
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned STEP_W = 4,
  localparam int unsigned ADDR_W = WORD_W - OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_out,
  output logic [WORD_W-1:0] acc_out,
  output logic              zero_out
);
  ctrl_t           cw;
  logic [OP_W-1:0] ir_op;
  logic            zero_flag;

  acc_cpu_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir_op     (ir_op),
    .zero_flag (zero_flag),
    .cw        (cw),
    .halted    (halted)
  );

  acc_cpu_dpath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw        (cw),
    .mem_rdata (mem_rdata),
    .ir_op     (ir_op),
    .mar       (mem_addr),
    .mdr       (mem_wdata),
    .pc        (pc_out),
    .acc       (acc_out),
    .zero_flag (zero_flag)
  );

  assign mem_rd   = cw.mem_rd;
  assign mem_wr   = cw.mem_wr;
  assign zero_out = zero_flag;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              halted,
  input logic [ADDR_W-1:0] pc_out,
  input logic [WORD_W-1:0] acc_out,
  input logic              zero_out
);
  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (!mem_rd && !mem_wr && $stable(pc_out) && $stable(acc_out)));

  // R6
  zero_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(zero_out) |-> (zero_out == (acc_out == '0)));

  // R13
  wr_holds_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> $stable(acc_out));
endmodule

bind acc_cpu acc_cpu_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .halted   (halted),
  .pc_out   (pc_out),
  .acc_out  (acc_out),
  .zero_out (zero_out)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 12;
  localparam int MEM_DEPTH  = 256;
  localparam int N_VEC      = 6;

  // {a, b, sum, z}
  localparam logic [63:0] ADD_VEC [N_VEC] = '{
    {16'h0003, 16'h0004, 16'h0007, 16'h0000},
    {16'hFFFF, 16'h0001, 16'h0000, 16'h0001},
    {16'h0000, 16'h0000, 16'h0000, 16'h0001},
    {16'h8000, 16'h8000, 16'h0000, 16'h0001},
    {16'h1234, 16'h0F0F, 16'h2143, 16'h0000},
    {16'h7FFF, 16'h0001, 16'h8000, 16'h0000}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd, mem_wr, halted, zero_out;
  logic [WORD_W-1:0] mem_wdata, mem_rdata, acc_out;
  logic [ADDR_W-1:0] pc_out;
  logic [WORD_W-1:0] mem [MEM_DEPTH];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .halted(halted), .pc_out(pc_out), .acc_out(acc_out), .zero_out(zero_out)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < MEM_DEPTH; i++) mem[i] = '0;
  endtask

  task automatic run(output int cyc);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=halt");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    @(negedge clk);

    // table of add vectors: LDA 80, ADD 81, STA 82, HALT
    for (int v = 0; v < N_VEC; v++) begin
      hold_reset();
      mem[0] = 16'h0080; mem[1] = 16'h2081; mem[2] = 16'h1082; mem[3] = 16'hF000;
      mem[8'h80] = ADD_VEC[v][63:48];
      mem[8'h81] = ADD_VEC[v][47:32];
      run(cyc);
      chk("R6 add result", 32'(acc_out), 32'(ADD_VEC[v][31:16]));
      chk("R6 zero flag", 32'(zero_out), 32'(ADD_VEC[v][0]));
      chk("R5 stored word", 32'(mem[8'h82]), 32'(ADD_VEC[v][31:16]));
      chk("R4 R5 R6 R11 cycle count", 32'(cyc), 32'd19);
    end

    // R1 reset state after nonzero accumulator
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pc reset", 32'(pc_out), 32'd0);
    chk("R1 acc reset", 32'(acc_out), 32'd0);
    chk("R1 halted reset", 32'(halted), 32'd0);
    chk("R1 zero reset", 32'(zero_out), 32'd0);
    // R2 fetch timing
    rst_n = 1'b1;
    chk("R2 no access in first fetch cycle", 32'(mem_rd | mem_wr), 32'd0);
    @(negedge clk);
    chk("R2 read strobe second cycle", 32'(mem_rd), 32'd1);
    chk("R1 first fetch address", 32'(mem_addr), 32'd0);
    @(negedge clk);
    chk("R2 pc incremented", 32'(pc_out), 32'd1);
    chk("R3 read strobe low in split cycle", 32'(mem_rd), 32'd0);

    // R4 load keeps zero flag
    hold_reset();
    mem[0] = 16'h2080; mem[1] = 16'h0081; mem[2] = 16'hF000;
    mem[8'h81] = 16'h0005;
    run(cyc);
    chk("R4 load value", 32'(acc_out), 32'h5);
    chk("R4 zero flag untouched by load", 32'(zero_out), 32'd1);

    // R7 R8 jump and branch
    hold_reset();
    mem[0] = 16'h2080; mem[1] = 16'h4020; mem[2] = 16'h2081; mem[3] = 16'h4010;
    mem[4] = 16'hF000; mem[8'h10] = 16'h3030; mem[8'h11] = 16'hF000;
    mem[8'h20] = 16'hF000; mem[8'h30] = 16'hF000; mem[8'h81] = 16'h0005;
    run(cyc);
    chk("R7 R8 final pc", 32'(pc_out), 32'h31);
    chk("R8 acc after branches", 32'(acc_out), 32'h5);
    chk("R7 R8 cycle count", 32'(cyc), 32'd26);

    // R9 load indirect
    hold_reset();
    mem[0] = 16'h5040; mem[1] = 16'hF000;
    mem[8'h40] = 16'h0050; mem[8'h50] = 16'hBEEF;
    run(cyc);
    chk("R9 indirect value", 32'(acc_out), 32'hBEEF);
    chk("R9 cycle count", 32'(cyc), 32'd11);
    chk("R9 pointer untouched", 32'(mem[8'h40]), 32'h50);

    // R10 pre-decrement
    hold_reset();
    mem[0] = 16'h6040; mem[1] = 16'hF000;
    mem[8'h40] = 16'h0051; mem[8'h50] = 16'h1234;
    run(cyc);
    chk("R10 predec value", 32'(acc_out), 32'h1234);
    chk("R10 pointer written back", 32'(mem[8'h40]), 32'h50);
    chk("R10 cycle count", 32'(cyc), 32'd13);

    // R10 pointer wrap from zero
    hold_reset();
    mem[0] = 16'h6040; mem[1] = 16'hF000;
    mem[8'hFF] = 16'h7777;
    run(cyc);
    chk("R10 wrapped value", 32'(acc_out), 32'h7777);
    chk("R10 wrapped pointer", 32'(mem[8'h40]), 32'hFFFF);

    // R12 undefined opcode
    hold_reset();
    mem[0] = 16'h7000; mem[1] = 16'hE081; mem[2] = 16'h0080; mem[3] = 16'hF000;
    mem[8'h80] = 16'h00AA;
    run(cyc);
    chk("R12 acc after unused opcodes", 32'(acc_out), 32'hAA);
    chk("R12 zero after unused opcodes", 32'(zero_out), 32'd0);
    chk("R12 cycle count", 32'(cyc), 32'd17);
    chk("R12 pc", 32'(pc_out), 32'd4);

    // R11 freeze after halt
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R11 halted held", 32'(halted), 32'd1);
      chk("R11 no access", 32'(mem_rd | mem_wr), 32'd0);
      chk("R11 pc frozen", 32'(pc_out), 32'd4);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule